// File: doc/BRIEF.md
# Ingress frame acceptance filter

The block watches a received Ethernet frame as it streams in one byte per beat, framed by start and end markers, and makes a single accept-or-drop decision for it. The decision looks at two things: the frame's destination address, compared with a programmed 48-bit station address, and the frame's total byte count, compared with a programmed lower threshold and a maximum payload length.

Software programs four words through a small register port: the low and high parts of the station address, a packed length-limit word, and a control word holding the unicast-filter enable. With the filter off, which is the setting used for promiscuous or all-multicast reception, every destination is accepted. With it on, a frame passes the address test when its destination equals the station address or carries the group bit. Frames that are too short or too long are always dropped.

Top module: `rx_frame_gate`

## Requirements
- R1: After reset the station address words read 0, the length-limit word reads 0x0040_05DC (threshold 64, maximum payload 1500), the control word reads 0 (filter off), and neither decision output is high.
- R2: A write with cfg_sel 0, 1, 2 or 3 updates the low address word, high address word, length-limit word or control word, and cfg_rdata shows the selected word. The high address word keeps only bits 31:16 and reads 0 in bits 15:0. The control word keeps only bit 28 and reads 0 elsewhere.
- R3: Destination byte k (k = 0 is the first byte of the frame) is compared with bits 8k+7:8k of the low address word for k = 0..3, with bits 23:16 of the high word for k = 4, and with bits 31:24 of the high word for k = 5.
- R4: With control bit 28 clear, a frame whose length is within limits is accepted whatever its destination.
- R5: The frame length is the count of beats from the start-marked byte through the end-marked byte inclusive, and a frame shorter than the threshold in bits 31:16 of the length-limit word is dropped; a frame exactly at the threshold passes the length test.
- R6: A frame longer than the maximum payload in bits 15:0 plus 18 bytes of header and checksum is dropped; a frame of exactly that length passes the length test.
- R7: With control bit 28 set, a frame whose destination is not a group address is accepted only when all six destination bytes equal the station address.
- R8: With control bit 28 set, a frame is accepted on address when bit 0 of its first byte (the group bit) is 1, which includes the all-ones broadcast address.
- R9: For each frame exactly one of frm_pass and frm_drop is high, for one cycle, in the cycle after the end-marked byte is presented. Valid bytes outside a frame (no start marker and no frame open) are ignored and give no pulse; a start marker inside an open frame abandons it and begins a new one.
- R10: With control bit 28 set, a non-group frame shorter than six bytes is dropped even when the length threshold allows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address low, 1 address high, 2 length limits, 3 control |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Contents of the selected register |
| rx_valid | input | 1 | A frame byte is presented this cycle |
| rx_data | input | 8 | Frame byte |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| frm_pass | output | 1 | One-cycle pulse: the frame just ended is accepted |
| frm_drop | output | 1 | One-cycle pulse: the frame just ended is dropped |

## Verification
The hardest situations to reach are the ones where the address and length verdicts interact at the edges: a frame that ends before its destination is complete while the threshold has been lowered to let it through, and frames sitting exactly on either length boundary. Directed frames reprogram the limit word to a small window and send frames of one to a few bytes, then step across the boundaries of both the default and the reprogrammed limits. Random frames mix station, group and random destinations with random lengths and filter settings, and abandoned frames followed by a fresh start marker exercise the restart path.

// File: rtl/rx_gate_pkg.sv
package rx_gate_pkg;

  localparam int unsigned DA_BYTES      = 6;
  localparam int unsigned OVERHEAD      = 18;
  localparam int unsigned UCAST_EN_BIT  = 28;
  localparam logic [31:0] LIMIT_DEFAULT = 32'h0040_05DC;

  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_ADDR_HI = 2'd1,
    SEL_LIMITS  = 2'd2,
    SEL_CTRL    = 2'd3
  } cfg_sel_e;

  // Station byte k from the two address words.
  function automatic logic [7:0] sta_byte(input logic [31:0] lo,
                                          input logic [31:0] hi,
                                          input logic [2:0]  k);
    logic [7:0] b;
    case (k)
      3'd0:    b = lo[7:0];
      3'd1:    b = lo[15:8];
      3'd2:    b = lo[23:16];
      3'd3:    b = lo[31:24];
      3'd4:    b = hi[23:16];
      default: b = hi[31:24];
    endcase
    return b;
  endfunction

  // Largest accepted frame: payload maximum plus header and checksum.
  function automatic logic [16:0] upper_len(input logic [15:0] max_payload);
    return {1'b0, max_payload} + 17'(OVERHEAD);
  endfunction

  function automatic logic length_fits(input logic [15:0] cnt,
                                       input logic [31:0] limits);
    return (cnt >= limits[31:16]) && ({1'b0, cnt} <= upper_len(limits[15:0]));
  endfunction

endpackage

// File: rtl/rx_gate_regs.sv
module rx_gate_regs
  import rx_gate_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [31:0]   addr_lo,
  output logic [31:0]   addr_hi,
  output logic [31:0]   limits,
  output logic          ucast_en
);

  cfg_sel_e sel_e;
  assign sel_e = cfg_sel_e'(sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_lo  <= '0;
      addr_hi  <= '0;
      limits   <= LIMIT_DEFAULT;
      ucast_en <= 1'b0;
    end else if (we) begin
      case (sel_e)
        SEL_ADDR_LO: addr_lo  <= wdata[31:0];
        SEL_ADDR_HI: addr_hi  <= {wdata[31:16], 16'h0000};
        SEL_LIMITS:  limits   <= wdata[31:0];
        default:     ucast_en <= wdata[UCAST_EN_BIT];
      endcase
    end
  end

  always_comb begin
    case (sel_e)
      SEL_ADDR_LO: rdata = addr_lo;
      SEL_ADDR_HI: rdata = addr_hi;
      SEL_LIMITS:  rdata = limits;
      default: begin
        rdata = '0;
        rdata[UCAST_EN_BIT] = ucast_en;
      end
    endcase
  end

  // R2: a limits write is visible on the next cycle
  a_r2_limits_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_LIMITS) |=> (limits == $past(wdata[31:0])));

endmodule

// File: rtl/rx_gate_addr.sv
module rx_gate_addr
  import rx_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        beat,
  input  logic        first,
  input  logic [7:0]  data,
  input  logic [31:0] addr_lo,
  input  logic [31:0] addr_hi,
  output logic [2:0]  nxt_idx,
  output logic        nxt_match,
  output logic        nxt_group
);

  logic [2:0] idx_q;
  logic       match_q;
  logic       group_q;

  always_comb begin
    nxt_idx   = idx_q;
    nxt_match = match_q;
    nxt_group = group_q;
    if (beat) begin
      if (first) begin
        nxt_idx   = 3'd1;
        nxt_match = (data == sta_byte(addr_lo, addr_hi, 3'd0));
        nxt_group = data[0];
      end else if (idx_q < 3'(DA_BYTES)) begin
        nxt_idx   = idx_q + 3'd1;
        nxt_match = match_q && (data == sta_byte(addr_lo, addr_hi, idx_q));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      match_q <= 1'b0;
      group_q <= 1'b0;
    end else begin
      idx_q   <= nxt_idx;
      match_q <= nxt_match;
      group_q <= nxt_group;
    end
  end

  // R8: the group bit of a start byte is captured
  a_r8_group_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && first && data[0]) |=> group_q);

  // R3: the destination index never passes six
  a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= 3'(DA_BYTES));

endmodule

// File: rtl/rx_gate_len.sv
module rx_gate_len #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             first,
  output logic [CNT_W-1:0] nxt_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    nxt_cnt = cnt_q;
    if (beat) begin
      if (first)                nxt_cnt = CNT_W'(1);
      else if (cnt_q != CNT_MAX) nxt_cnt = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt_cnt;
  end

  // R5: a start byte counts as the first byte
  a_r5_start_counts_one: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && first) |=> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/rx_frame_gate.sv
module rx_frame_gate
  import rx_gate_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  output logic        frm_pass,
  output logic        frm_drop
);

  logic [31:0]      addr_lo, addr_hi, limits;
  logic             ucast_en;
  logic             in_frame;
  logic             beat, first, done;
  logic [2:0]       nxt_idx;
  logic             nxt_match, nxt_group;
  logic [CNT_W-1:0] nxt_cnt;
  logic             addr_ok, len_ok;

  assign beat  = rx_valid && (rx_sof || in_frame);
  assign first = rx_valid && rx_sof;
  assign done  = beat && rx_eof;

  rx_gate_regs #(.DW(32)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .addr_lo(addr_lo), .addr_hi(addr_hi), .limits(limits),
    .ucast_en(ucast_en)
  );

  rx_gate_addr u_addr (
    .clk(clk), .rst_n(rst_n), .beat(beat), .first(first), .data(rx_data),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .nxt_idx(nxt_idx),
    .nxt_match(nxt_match), .nxt_group(nxt_group)
  );

  rx_gate_len #(.CNT_W(CNT_W)) u_len (
    .clk(clk), .rst_n(rst_n), .beat(beat), .first(first), .nxt_cnt(nxt_cnt)
  );

  assign addr_ok = !ucast_en || nxt_group ||
                   ((nxt_idx == 3'(DA_BYTES)) && nxt_match);
  assign len_ok  = length_fits(16'(nxt_cnt), limits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      frm_pass <= 1'b0;
      frm_drop <= 1'b0;
    end else begin
      if (beat) in_frame <= !rx_eof;
      frm_pass <= done && addr_ok && len_ok;
      frm_drop <= done && !(addr_ok && len_ok);
    end
  end

  // R9: the two verdicts never coincide
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_pass && frm_drop));

  // R9: a verdict only follows an end-marked byte
  a_r9_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_pass || frm_drop) |-> $past(rx_valid && rx_eof));

  // R9: a closed frame with a stray byte gives no verdict
  a_r9_stray_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame && rx_valid && !rx_sof) |=> !(frm_pass || frm_drop));

endmodule

// File: tb/rx_frame_gate_test.sv
`timescale 1ns/1ps
module rx_frame_gate_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_sof = 1'b0;
  logic        rx_eof = 1'b0;
  logic        frm_pass, frm_drop;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  logic [31:0] m_lo = '0, m_hi = '0, m_lim = 32'h0040_05DC;
  logic        m_en = 1'b0;

  always #4 clk = ~clk;

  rx_frame_gate uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .frm_pass(frm_pass), .frm_drop(frm_drop)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] station();
    return {m_hi[31:16], m_lo};
  endfunction

  // Expected verdict: 1 accept, 0 drop
  function automatic logic want_pass(input int n, input logic [47:0] da);
    logic a_ok, l_ok;
    a_ok = !m_en || da[0] || (n >= 6 && da == station());
    l_ok = (n >= int'(m_lim[31:16])) && (n <= int'(m_lim[15:0]) + 18);
    return a_ok && l_ok;
  endfunction

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (s)
      2'd0: m_lo = d;
      2'd1: m_hi = {d[31:16], 16'h0};
      2'd2: m_lim = d;
      default: m_en = d[28];
    endcase
  endtask

  task automatic rd(input string req, input logic [1:0] s, input logic [31:0] exp);
    @(negedge clk);
    cfg_sel = s;
    #1 chk(req, cfg_rdata, exp);
  endtask

  // Drive n bytes; destination bytes from da. Optionally no end marker.
  task automatic drive(input int n, input logic [47:0] da, input bit close);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_sof   = (i == 0);
      rx_eof   = close && (i == n - 1);
      rx_data  = (i < 6) ? da[8*i +: 8] : 8'($urandom);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic frame(input string req, input int n, input logic [47:0] da);
    logic e;
    e = want_pass(n, da);
    drive(n, da, 1'b1);
    chk(req, {30'd0, frm_pass, frm_drop}, {30'd0, e, !e});
    @(negedge clk);
    chk({req, " single cycle"}, {30'd0, frm_pass, frm_drop}, 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done_flag) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [47:0] da;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd("R1 addr lo", 2'd0, 32'h0);
    rd("R1 addr hi", 2'd1, 32'h0);
    rd("R1 limits", 2'd2, 32'h0040_05DC);
    rd("R1 control", 2'd3, 32'h0);
    chk("R1 outputs", {30'd0, frm_pass, frm_drop}, 32'd0);

    // R2 write and readback, masked fields
    wr(2'd1, 32'h5544_FFFF);
    rd("R2 addr hi mask", 2'd1, 32'h5544_0000);
    wr(2'd0, 32'h3322_1100);
    rd("R2 addr lo", 2'd0, 32'h3322_1100);
    wr(2'd3, 32'hFFFF_FFFF);
    rd("R2 control mask", 2'd3, 32'h1000_0000);
    wr(2'd3, 32'h0);

    // R4 filter off: arbitrary unicast passes
    frame("R4 filter off", 64, 48'h0A0B_0C0D_0E02);
    // R5 threshold boundary
    frame("R5 below threshold", 63, 48'h1);
    frame("R5 at threshold", 64, 48'h2);
    // R6 upper boundary
    frame("R6 at maximum", 1518, 48'h4);
    frame("R6 above maximum", 1519, 48'h4);

    // R3 / R7 filter on
    wr(2'd3, 32'h1000_0000);
    frame("R3 R7 station match", 80, 48'h5544_3322_1100);
    frame("R7 last byte differs", 80, 48'h5644_3322_1100);
    frame("R3 bytes 4 and 5 swapped", 80, 48'h4455_3322_1100);
    frame("R7 first byte differs", 80, 48'h5544_3322_1102);
    // R8 group and broadcast
    frame("R8 broadcast", 70, 48'hFFFF_FFFF_FFFF);
    frame("R8 multicast", 70, 48'h1234_5678_9A01);

    // R10 short unicast with relaxed threshold
    wr(2'd2, 32'h0001_0020);
    frame("R10 short unicast prefix", 4, 48'h5544_3322_1100);
    frame("R10 short group", 3, 48'h0000_0000_0001);
    frame("R6 small limit at max", 50, 48'h5544_3322_1100);
    frame("R6 small limit above", 51, 48'h5544_3322_1100);
    wr(2'd2, 32'h0040_05DC);

    // R9 stray bytes outside a frame are ignored
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = 1'b0; rx_eof = (i == 2); rx_data = 8'h55;
      @(negedge clk);
      rx_valid = 1'b0; rx_eof = 1'b0;
      chk("R9 stray byte no pulse", {30'd0, frm_pass, frm_drop}, 32'd0);
    end
    // R9 restart: abandoned frame then fresh start
    drive(10, 48'h5544_3322_1100, 1'b0);
    chk("R9 open frame no pulse", {30'd0, frm_pass, frm_drop}, 32'd0);
    frame("R9 restart counts anew", 64, 48'h5544_3322_1100);

    // Random mix
    for (int k = 0; k < 40; k++) begin
      int n;
      int pick;
      wr(2'd3, ($urandom % 2) ? 32'h1000_0000 : 32'h0);
      pick = $urandom % 4;
      case (pick)
        0: da = station();
        1: da = {$urandom, $urandom} | 48'h1;
        2: da = {$urandom, $urandom} & ~48'h1;
        default: da = station() ^ (48'h1 << (8 * ($urandom % 6) + 1));
      endcase
      n = ($urandom % 4 == 0) ? 1400 + int'($urandom % 200) : 1 + int'($urandom % 200);
      frame(m_en ? "R7 R8 random" : "R4 random", n, da);
    end

    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule